// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the software-visible register bank of a 16550-style serial port. A simple single-cycle read/write bus with 8-bit data addresses eight word slots. The bus carries the word index, so byte offset 0x00 is index 0 and byte offset 0x1C is index 7. The bank stores the line control, modem control, scratch, interrupt enable and two divisor bytes. It gives their values to the shifter, the baud generator and the modem pins. The serial shifter, the baud generator and the FIFO storage sit outside the bank. The fill and error state of those parts comes in on status inputs.

The divisor-latch access bit is bit 7 of the line control register. It banks the two lowest slots. When the bit is set, slots 0 and 1 are the low and high divisor bytes. When it is clear, slot 0 is receive data on read and transmit data on write, and slot 1 is the interrupt enable register. A transmit write and a receive read each give a strobe. The strobe is high in the same cycle as the bus access, and every cycle with `bus_sel` high counts as one access.

The bank builds the interrupt identification value from the enabled sources by fixed priority. It builds the line status value from the status inputs and from error flags that stay set until software reads them. It builds the modem status value from the pin levels and from delta flags. Reading the line status register clears its sticky errors, and reading the modem status register clears its deltas.

Top module: `uart_regbank`

## Requirements
- R1: After reset, LCR, IER, MCR, SCR and both divisor bytes read 0x00. With `thr_empty`=1, `tsr_empty`=1 and every other status input at 0, IIR (slot 2) reads 0x01, LSR (slot 5) reads 0x60, MSR (slot 4) reads 0x00 and `irq` is 0.
- R2: When LCR bit 7 is 1, slot 0 reads and writes the divisor low byte and slot 1 the divisor high byte. `div_q` shows {high, low}. When LCR bit 7 is 0, slot 1 reads and writes IER. A write to slot 0 then leaves the divisor unchanged, and a write to the divisor leaves IER unchanged.
- R3: A write to slot 0 with LCR bit 7 at 0 drives `tx_wr`=1 and `tx_data`=`bus_wdata` in that cycle. A read of slot 0 with LCR bit 7 at 0 drives `rx_rd`=1 and returns `rx_data`. Neither strobe rises for a slot 0 access while LCR bit 7 is 1.
- R4: LCR (slot 3) and SCR (slot 7) read back all 8 written bits. MCR (slot 4, write) keeps bits 5:0, and reading those bits back through `mcr_q` shows bits 7:6 as 0.
- R5: IIR bit 0 is 1 when no enabled source is pending. Otherwise bits 3:1 hold 3'b011 for line status, 3'b010 for receive data, 3'b001 for transmit holding empty and 3'b000 for modem status, and that order is the priority. The enables are IER bit 2 for line status, bit 0 for receive data, bit 1 for transmit holding empty and bit 3 for modem status. A line-status source is any of LSR bits 4:1.
- R6: A write to slot 2 pulses `fcr_wr` with `fcr_data`=`bus_wdata`. Written bit 0 sets (1) or clears (0) FIFO mode. IIR bits 7:6 read 2'b11 in FIFO mode and 2'b00 otherwise. The FCR write has no other effect on IIR.
- R7: LSR bits are 0 `rx_ready`, 1 `rx_overrun` level, 2 parity, 3 framing, 4 break, 5 `thr_empty`, 6 transmitter empty and 7 `fifo_err`. A one-cycle pulse on `ev_parity`, `ev_framing` or `ev_break` sets its bit, and the bit stays set until an LSR read, which clears bits 4:2.
- R8: LSR bit 6 is 1 only when `thr_empty` and `tsr_empty` are both 1.
- R9: MSR bits 7:4 show DCD, RI, DSR and CTS (`modem_in` bits 3, 2, 1, 0). Bits 0, 1 and 3 are set by any change of CTS, DSR and DCD. Bit 2 is set by RI going from 1 to 0. An MSR read clears bits 3:0.
- R10: `irq` is 1 exactly when IIR bit 0 is 0.
- R11: Writes to slots 5 and 6 change no register: LCR, SCR, IER, LSR and IIR read the same afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_widx | input | 3 | Word slot index (byte offset / 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the slot |
| tx_wr | output | 1 | Transmit data write strobe |
| tx_data | output | 8 | Transmit byte |
| rx_rd | output | 1 | Receive data read strobe |
| rx_data | input | 8 | Receive byte at the head of the receive path |
| fcr_wr | output | 1 | FIFO control write strobe |
| fcr_data | output | 8 | FIFO control byte |
| rx_ready | input | 1 | Receive data available |
| thr_empty | input | 1 | Transmit holding path empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rx_overrun | input | 1 | Overrun level |
| ev_parity | input | 1 | Parity error event |
| ev_framing | input | 1 | Framing error event |
| ev_break | input | 1 | Break event |
| fifo_err | input | 1 | Error somewhere in the receive FIFO |
| modem_in | input | 4 | {DCD, RI, DSR, CTS} levels |
| lcr_q | output | 8 | Line control value |
| ier_q | output | 8 | Interrupt enable value |
| mcr_q | output | 6 | Modem control value |
| div_q | output | 16 | Baud divisor {high, low} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is a single-cycle pulse sampled at the clock edge. They also assume that `modem_in` is already synchronised to `clk`, and that the status levels change only between edges. They treat each cycle with `bus_sel` high as one complete access. The stimulus drives every input one nanosecond after a rising edge. It raises the error events for exactly one cycle, and it leaves an idle cycle between bus accesses. As a result, no read-to-clear ever meets an event in the same cycle.

// File: rtl/uart_rb_pkg.sv
// Shared slot map, interrupt codes and line status layout for the register bank.
package uart_rb_pkg;
    localparam int SLOT_W = 3;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_DATA = 3'd0,
        SLOT_IER  = 3'd1,
        SLOT_IIR  = 3'd2,
        SLOT_LCR  = 3'd3,
        SLOT_MCR  = 3'd4,
        SLOT_LSR  = 3'd5,
        SLOT_NONE = 3'd6,
        SLOT_SCR  = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        IID_MODEM = 2'b00,
        IID_THRE  = 2'b01,
        IID_RXD   = 2'b10,
        IID_LINE  = 2'b11
    } iid_e;

    typedef struct packed {
        logic fifo_err;
        logic temt;
        logic thre;
        logic brk;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } lsr_t;
endpackage

// File: rtl/uart_rb_ctrl.sv
// Writable control state: line control, interrupt enable, modem control,
// scratch, divisor bytes and the FIFO mode flag. It assumes the write
// strobes are already decoded and mutually exclusive.
module uart_rb_ctrl #(
    parameter int DW        = 8,
    parameter int MCR_W     = 6,
    parameter int DIV_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-1:0]           wdata,
    input  logic                    wr_lcr,
    input  logic                    wr_ier,
    input  logic                    wr_mcr,
    input  logic                    wr_scr,
    input  logic                    wr_fcr,
    input  logic [DIV_BYTES-1:0]    wr_div,
    output logic [DW-1:0]           lcr_q,
    output logic [DW-1:0]           ier_q,
    output logic [MCR_W-1:0]        mcr_q,
    output logic [DW-1:0]           scr_q,
    output logic [DIV_BYTES*DW-1:0] div_q,
    output logic                    fifo_en_q
);
    // Plain registers loaded by their own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q     <= '0;
            ier_q     <= '0;
            mcr_q     <= '0;
            scr_q     <= '0;
            fifo_en_q <= 1'b0;
        end else begin
            if (wr_lcr) lcr_q <= wdata;
            if (wr_ier) ier_q <= wdata;
            if (wr_mcr) mcr_q <= wdata[MCR_W-1:0];
            if (wr_scr) scr_q <= wdata;
            if (wr_fcr) fifo_en_q <= wdata[0];
        end
    end

    // One register per divisor byte.
    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk) begin
            if (!rst_n)        div_q[b*DW +: DW] <= '0;
            else if (wr_div[b]) div_q[b*DW +: DW] <= wdata;
        end
    end

    // R2: divisor changes only on a divisor write
    p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div == '0) |=> $stable(div_q));
    // R6: FIFO mode changes only on a FIFO control write
    p_fifo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fcr |=> $stable(fifo_en_q));
endmodule

// File: rtl/uart_rb_status.sv
// Line and modem status assembly. The error bits stay set until the line
// status register is read. The modem deltas are edge flags cleared by a
// modem status read. It assumes the events are one-cycle pulses and that
// modem_in is synchronous to clk. An event wins over a clear in the same cycle.
module uart_rb_status
    import uart_rb_pkg::*;
#(
    parameter int MODEM_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_ready,
    input  logic               thr_empty,
    input  logic               tsr_empty,
    input  logic               rx_overrun,
    input  logic               ev_parity,
    input  logic               ev_framing,
    input  logic               ev_break,
    input  logic               fifo_err,
    input  logic [MODEM_N-1:0] modem_in,
    input  logic               rd_lsr,
    input  logic               rd_msr,
    output lsr_t               lsr,
    output logic [2*MODEM_N-1:0] msr
);
    // Bit 2 (ring) flags only its trailing edge; the others flag any change.
    localparam logic [MODEM_N-1:0] TRAIL_ONLY = MODEM_N'(4'b0100);

    logic [2:0]         err_q;      // {break, framing, parity}
    logic [MODEM_N-1:0] prev_q;
    logic [MODEM_N-1:0] delta_q;
    logic [MODEM_N-1:0] edge_hit;

    // Sticky error flags: cleared by a line status read, set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (rd_lsr ? 3'b000 : err_q) | {ev_break, ev_framing, ev_parity};
    end

    // Edge detection per modem line.
    for (genvar i = 0; i < MODEM_N; i++) begin : g_edge
        if (TRAIL_ONLY[i]) begin : g_trail
            assign edge_hit[i] = prev_q[i] & ~modem_in[i];
        end else begin : g_any
            assign edge_hit[i] = prev_q[i] ^ modem_in[i];
        end
    end

    // Previous levels and delta flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= modem_in;
            delta_q <= '0;
        end else begin
            prev_q  <= modem_in;
            delta_q <= (rd_msr ? '0 : delta_q) | edge_hit;
        end
    end

    // Assemble the read values.
    always_comb begin
        lsr.fifo_err = fifo_err;
        lsr.temt     = thr_empty & tsr_empty;
        lsr.thre     = thr_empty;
        lsr.brk      = err_q[2];
        lsr.fe       = err_q[1];
        lsr.pe       = err_q[0];
        lsr.oe       = rx_overrun;
        lsr.dr       = rx_ready;
        msr          = {modem_in, delta_q};
    end

    // R7: without a line status read no error flag drops
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lsr |=> ((err_q & $past(err_q)) == $past(err_q)));
    // R9: a modem status read with no new edge leaves the deltas clear
    p_msr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && edge_hit == '0) |=> (delta_q == '0));
endmodule

// File: rtl/uart_rb_irq.sv
// Interrupt identification by fixed priority: line status, receive data,
// transmit holding empty, modem status. It assumes its inputs are the live
// status values. The output is combinational.
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ier_en,      // {modem, line, thre, rx}
    input  logic       line_err,
    input  logic       data_rdy,
    input  logic       thre,
    input  logic       modem_delta,
    input  logic       fifo_en,
    output logic [7:0] iir,
    output logic       irq
);
    iid_e id;
    logic pending;

    // Priority choice among the enabled sources.
    always_comb begin
        pending = 1'b1;
        id      = IID_MODEM;
        if (ier_en[2] && line_err)         id = IID_LINE;
        else if (ier_en[0] && data_rdy)    id = IID_RXD;
        else if (ier_en[1] && thre)        id = IID_THRE;
        else if (ier_en[3] && modem_delta) id = IID_MODEM;
        else                               pending = 1'b0;
        iir = {{2{fifo_en}}, 2'b00, 1'b0, id, ~pending};
        irq = pending;
    end

    // R5: a raised request always has an enabled source behind it
    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ier_en & {modem_delta, line_err, thre, data_rdy}) != 4'b0000));
    // R5: an enabled line error always takes the code
    p_line_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_en[2] && line_err) |-> (iir[3:0] == 4'b0110));
endmodule

// File: rtl/uart_regbank.sv
// Top of the serial port register bank. It decodes the word slot and the
// divisor-latch bank bit into write, clear and strobe signals, and it muxes
// the read data. It assumes each cycle with bus_sel high is one access.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MCR_W     = 6,
    parameter int DIV_BYTES = 2,
    parameter int MODEM_N   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [SLOT_W-1:0]       bus_widx,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    output logic                    tx_wr,
    output logic [DW-1:0]           tx_data,
    output logic                    rx_rd,
    input  logic [DW-1:0]           rx_data,
    output logic                    fcr_wr,
    output logic [DW-1:0]           fcr_data,
    input  logic                    rx_ready,
    input  logic                    thr_empty,
    input  logic                    tsr_empty,
    input  logic                    rx_overrun,
    input  logic                    ev_parity,
    input  logic                    ev_framing,
    input  logic                    ev_break,
    input  logic                    fifo_err,
    input  logic [MODEM_N-1:0]      modem_in,
    output logic [DW-1:0]           lcr_q,
    output logic [DW-1:0]           ier_q,
    output logic [MCR_W-1:0]        mcr_q,
    output logic [DIV_BYTES*DW-1:0] div_q,
    output logic                    irq
);
    localparam int BANK_BIT = DW - 1;

    slot_e                slot;
    logic                 wr_acc, rd_acc, bank;
    logic                 wr_lcr, wr_ier, wr_mcr, wr_scr;
    logic [DIV_BYTES-1:0] wr_div;
    logic                 rd_lsr, rd_msr;
    logic [DW-1:0]        scr_q;
    logic                 fifo_en;
    lsr_t                 lsr;
    logic [2*MODEM_N-1:0] msr;
    logic [7:0]           iir;

    // Access decode with the divisor-latch bank selection.
    always_comb begin
        slot     = slot_e'(bus_widx);
        wr_acc   = bus_sel &  bus_wr;
        rd_acc   = bus_sel & ~bus_wr;
        bank     = lcr_q[BANK_BIT];
        wr_div   = '0;
        wr_div[0] = wr_acc &  bank & (slot == SLOT_DATA);
        wr_div[1] = wr_acc &  bank & (slot == SLOT_IER);
        wr_ier   = wr_acc & ~bank & (slot == SLOT_IER);
        wr_lcr   = wr_acc & (slot == SLOT_LCR);
        wr_mcr   = wr_acc & (slot == SLOT_MCR);
        wr_scr   = wr_acc & (slot == SLOT_SCR);
        fcr_wr   = wr_acc & (slot == SLOT_IIR);
        fcr_data = bus_wdata;
        tx_wr    = wr_acc & ~bank & (slot == SLOT_DATA);
        tx_data  = bus_wdata;
        rx_rd    = rd_acc & ~bank & (slot == SLOT_DATA);
        rd_lsr   = rd_acc & (slot == SLOT_LSR);
        rd_msr   = rd_acc & (slot == SLOT_MCR);
    end

    uart_rb_ctrl #(.DW(DW), .MCR_W(MCR_W), .DIV_BYTES(DIV_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
        .wr_lcr(wr_lcr), .wr_ier(wr_ier), .wr_mcr(wr_mcr), .wr_scr(wr_scr),
        .wr_fcr(fcr_wr), .wr_div(wr_div),
        .lcr_q(lcr_q), .ier_q(ier_q), .mcr_q(mcr_q), .scr_q(scr_q),
        .div_q(div_q), .fifo_en_q(fifo_en)
    );

    uart_rb_status #(.MODEM_N(MODEM_N)) u_status (
        .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .thr_empty(thr_empty),
        .tsr_empty(tsr_empty), .rx_overrun(rx_overrun), .ev_parity(ev_parity),
        .ev_framing(ev_framing), .ev_break(ev_break), .fifo_err(fifo_err),
        .modem_in(modem_in), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
        .lsr(lsr), .msr(msr)
    );

    uart_rb_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ier_en(ier_q[3:0]),
        .line_err(lsr.oe | lsr.pe | lsr.fe | lsr.brk),
        .data_rdy(lsr.dr), .thre(lsr.thre),
        .modem_delta(msr[MODEM_N-1:0] != '0), .fifo_en(fifo_en),
        .iir(iir), .irq(irq)
    );

    // Read data selection by slot and bank.
    always_comb begin
        unique case (slot)
            SLOT_DATA: bus_rdata = bank ? div_q[DW-1:0] : rx_data;
            SLOT_IER:  bus_rdata = bank ? div_q[2*DW-1:DW] : ier_q;
            SLOT_IIR:  bus_rdata = DW'(iir);
            SLOT_LCR:  bus_rdata = lcr_q;
            SLOT_MCR:  bus_rdata = DW'(msr);
            SLOT_LSR:  bus_rdata = DW'(lsr);
            SLOT_SCR:  bus_rdata = scr_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R3: the transmit strobe never fires while the divisor bank is selected
    p_tx_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> !lcr_q[BANK_BIT]);
    // R3: the receive strobe never comes with a write or with the divisor bank
    p_rx_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> (!bus_wr && !lcr_q[BANK_BIT]));
endmodule

// File: tb/uart_regbank_bench.sv
// Scoreboard bench: bus read tasks queue expected values, and a monitor pops
// them at the falling edge of the access cycle and compares.
module uart_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_widx = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        tx_wr, rx_rd, fcr_wr, irq;
    logic [7:0]  tx_data, fcr_data, rx_data = 8'h00;
    logic        rx_ready = 1'b0, thr_empty = 1'b1, tsr_empty = 1'b1, rx_overrun = 1'b0;
    logic        ev_parity = 1'b0, ev_framing = 1'b0, ev_break = 1'b0, fifo_err = 1'b0;
    logic [3:0]  modem_in = '0;
    logic [7:0]  lcr_q, ier_q;
    logic [5:0]  mcr_q;
    logic [15:0] div_q;

    int nchk = 0, nerr = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       s_tx, s_rx, s_fcr;
    logic [7:0] s_txd, s_fcrd;

    localparam logic [2:0] S_DATA = 3'd0, S_IER = 3'd1, S_IIR = 3'd2, S_LCR = 3'd3,
                           S_MCR = 3'd4, S_LSR = 3'd5, S_NONE = 3'd6, S_SCR = 3'd7;

    always #2 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .fcr_wr(fcr_wr), .fcr_data(fcr_data), .rx_ready(rx_ready),
        .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rx_overrun(rx_overrun),
        .ev_parity(ev_parity), .ev_framing(ev_framing), .ev_break(ev_break),
        .fifo_err(fifo_err), .modem_in(modem_in), .lcr_q(lcr_q), .ier_q(ier_q),
        .mcr_q(mcr_q), .div_q(div_q), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read cycle against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic access(logic w, logic [2:0] idx, logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = w; bus_widx = idx; bus_wdata = d;
        @(negedge clk);
        s_tx = tx_wr; s_txd = tx_data; s_rx = rx_rd; s_fcr = fcr_wr; s_fcrd = fcr_data;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(logic [2:0] idx, logic [7:0] d);
        access(1'b1, idx, d);
    endtask

    task automatic rd(logic [2:0] idx, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, idx, 8'h00);
    endtask

    task automatic pulse(logic p, logic f, logic b);
        @(posedge clk); #1;
        ev_parity = p; ev_framing = f; ev_break = b;
        @(posedge clk); #1;
        ev_parity = 1'b0; ev_framing = 1'b0; ev_break = 1'b0;
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    initial begin
        #(4 * 150000);
        check("watchdog", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(S_LCR, 8'h00, "R1 lcr");
        rd(S_IER, 8'h00, "R1 ier");
        rd(S_SCR, 8'h00, "R1 scr");
        rd(S_IIR, 8'h01, "R1 iir");
        rd(S_LSR, 8'h60, "R1 lsr");
        rd(S_MCR, 8'h00, "R1 msr");
        check("R1 mcr", {26'd0, mcr_q}, 32'h0);
        check("R1 div", {16'd0, div_q}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R4 readback
        wr(S_SCR, 8'hA5);  rd(S_SCR, 8'hA5, "R4 scr");
        wr(S_LCR, 8'h1B);  rd(S_LCR, 8'h1B, "R4 lcr");
        wr(S_MCR, 8'hFF);
        check("R4 mcr", {26'd0, mcr_q}, 32'h3F);

        // R2 / R3 banking and strobes
        wr(S_LCR, 8'h80);
        wr(S_DATA, 8'h34);
        check("R3 no tx strobe in divisor bank", {31'd0, s_tx}, 32'd0);
        wr(S_IER, 8'h12);
        rx_data = 8'hC3;
        rd(S_DATA, 8'h34, "R2 dll");
        check("R3 no rx strobe in divisor bank", {31'd0, s_rx}, 32'd0);
        rd(S_IER, 8'h12, "R2 dlm");
        check("R2 div", {16'd0, div_q}, 32'h1234);
        wr(S_LCR, 8'h03);
        rd(S_IER, 8'h00, "R2 ier untouched");
        wr(S_DATA, 8'h5A);
        check("R3 tx strobe", {31'd0, s_tx}, 32'd1);
        check("R3 tx data", {24'd0, s_txd}, 32'h5A);
        rd(S_DATA, 8'hC3, "R3 rx data");
        check("R3 rx strobe", {31'd0, s_rx}, 32'd1);
        check("R2 div after tx", {16'd0, div_q}, 32'h1234);

        // R6 FIFO control
        wr(S_IIR, 8'h01);
        check("R6 fcr strobe", {31'd0, s_fcr}, 32'd1);
        check("R6 fcr data", {24'd0, s_fcrd}, 32'h01);
        rd(S_IIR, 8'hC1, "R6 fifo on");
        wr(S_IIR, 8'h00);  rd(S_IIR, 8'h01, "R6 fifo off");
        wr(S_IIR, 8'hC7);  rd(S_IIR, 8'hC1, "R6 fifo on again");

        // R5 / R10 priority
        wr(S_IER, 8'h0F);
        rd(S_IIR, 8'hC2, "R5 thre");
        check("R10 irq thre", {31'd0, irq}, 32'd1);
        step; rx_ready = 1'b1;
        rd(S_IIR, 8'hC4, "R5 rx over thre");
        pulse(1'b1, 1'b0, 1'b0);
        rd(S_IIR, 8'hC6, "R5 line over rx");
        rd(S_LSR, 8'h65, "R7 parity sticky");
        rd(S_LSR, 8'h61, "R7 parity cleared");
        rd(S_IIR, 8'hC4, "R5 back to rx");

        // R7 overrun level and break/framing
        step; rx_overrun = 1'b1;
        rd(S_LSR, 8'h63, "R7 overrun");
        rd(S_IIR, 8'hC6, "R5 overrun line");
        step; rx_overrun = 1'b0;
        pulse(1'b0, 1'b1, 1'b1);
        rd(S_LSR, 8'h79, "R7 break framing");
        rd(S_LSR, 8'h61, "R7 cleared");
        step; fifo_err = 1'b1;
        rd(S_LSR, 8'hE1, "R7 fifo error");
        step; fifo_err = 1'b0;

        // R8 transmitter empty
        step; tsr_empty = 1'b0;
        rd(S_LSR, 8'h21, "R8 shifter busy");
        step; tsr_empty = 1'b1; thr_empty = 1'b0;
        rd(S_LSR, 8'h01, "R8 holding busy");
        step; rx_ready = 1'b0;
        rd(S_IIR, 8'hC1, "R5 none pending");
        check("R10 irq idle", {31'd0, irq}, 32'd0);

        // R9 modem status
        step; modem_in = 4'b0001;
        rd(S_IIR, 8'hC0, "R5 modem");
        check("R10 irq modem", {31'd0, irq}, 32'd1);
        rd(S_MCR, 8'h11, "R9 cts delta");
        rd(S_MCR, 8'h10, "R9 delta cleared");
        rd(S_IIR, 8'hC1, "R9 modem irq gone");
        step; modem_in = 4'b0101;
        rd(S_MCR, 8'h50, "R9 ri rise no delta");
        step; modem_in = 4'b0001;
        rd(S_MCR, 8'h14, "R9 ri trailing");
        rd(S_MCR, 8'h10, "R9 cleared again");
        step; modem_in = 4'b1001;
        rd(S_MCR, 8'h98, "R9 dcd delta");
        rd(S_MCR, 8'h90, "R9 dcd cleared");

        // R11 ignored slots
        wr(S_LSR, 8'hFF);
        wr(S_NONE, 8'hFF);
        rd(S_LCR, 8'h03, "R11 lcr");
        rd(S_SCR, 8'hA5, "R11 scr");
        rd(S_IER, 8'h0F, "R11 ier");
        rd(S_LSR, 8'h00, "R11 lsr");
        rd(S_IIR, 8'hC1, "R11 iir");

        step;
        check("scoreboard drained", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule